// File: doc/BRIEF.md
# Sequential-Mode DMA Channel Engine

This block is one DMA channel that moves data between a stepping memory location and a fixed I/O location, one unit per request. Software loads a 24-bit memory pointer, a 16-bit I/O offset, a 16-bit transfer count and a control word, then enables the channel. Each request pulse then causes one bus read followed by one bus write. After the write, the memory pointer moves by one byte or one word, up or down, and the count drops by one. When the count reaches zero, the channel disables itself and raises a sticky completion flag. That flag can also drive an interrupt line.

The I/O side always sits in the top 64 KiB page: its upper 8 address bits are forced to ones, and it never moves. A direction bit selects the roles. With direction 0, memory is the source and I/O is the destination. With direction 1, the roles are swapped. A single-cycle bus is assumed: read data is taken at the end of the read cycle and held in an internal latch for the write cycle.

The controller has three states, named ST_IDLE, ST_READ and ST_WRITE, with these transitions:
- **ST_IDLE to ST_READ (start):** taken when the channel is enabled and a request is present or pending.
- **ST_READ to ST_WRITE (fetch):** always taken.
- **ST_WRITE to ST_IDLE (retire):** always taken. At this edge the pointer and the count are updated.

While the controller is outside ST_IDLE, register writes are discarded. Requests arriving in that time are remembered as one pending request.

Top module: `dma_seq_chan`

## Requirements
- R1: After reset, every register reads zero, both bus strobes are low, and `busy`, `done` and `irq` are low.
- R2: A write with `cfg_we` while idle loads the register chosen by `cfg_sel`: 0 is the memory pointer (24 bits), 1 is the I/O offset (low 16 bits), 2 is the count (low 16 bits) and 3 is control. `cfg_rdata` returns the selected register combinationally. The control bits are: bit 0 enable, bit 1 word size, bit 2 step down, bit 3 direction, bit 4 interrupt enable. Control readback also shows the done flag at bit 7.
- R3: A request seen at a clock edge while idle and enabled produces one `bus_rd` cycle in the next cycle at the source address, then exactly one `bus_wr` cycle at the destination address carrying the read data, then a return to idle.
- R4: With direction 0 the source is the memory pointer and the destination is `{8'hFF, io offset}`. With direction 1 these roles are swapped.
- R5: At the end of each write, the memory pointer moves by 1 for bytes or by 2 for words, upward, or downward when step-down is set. It wraps modulo 2^24.
- R6: In byte mode only `bus_rdata[7:0]` is carried, and `bus_wdata[15:8]` is zero.
- R7: The count decreases by one per transfer. The write that brings it to zero clears the enable bit, sets `done`, and raises `irq` only when interrupt enable is set.
- R8: `done` stays set until the next control write. While the channel is disabled, requests cause no bus activity.
- R9: Register writes issued while `busy` is high have no effect.
- R10: A request arriving during a transfer is held, and it starts the next transfer after the return to idle. A request during the final write of a run is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and readback |
| cfg_wdata | input | 24 | Register write data |
| cfg_rdata | output | 24 | Readback of the selected register |
| req | input | 1 | Transfer request |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled at the end of a read cycle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Sticky end-of-run flag |
| irq | output | 1 | Completion interrupt |

## Verification
Two pairs of events can fall in the same clock edge.

The first pair is a request and the final retire of a run. The bench pulses a request during the last `bus_wr` cycle. The test passes only if no further `bus_rd` appears, and `done` is set with the count at zero.

The second pair is a register write and a request arriving while a transfer is underway. The bench issues both during a `bus_rd` cycle. The test passes only if the pointer keeps the value produced by stepping and ignores the written value, and if the held request is served with the stepped address one cycle after the return to idle.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dmach_state_e;

    // control word, bit 0 is the enable
    typedef struct packed {
        logic irq_en;
        logic dir_in;
        logic step_down;
        logic word;
        logic en;
    } dmach_ctrl_t;

    localparam int unsigned CTRL_W = $bits(dmach_ctrl_t);

    localparam logic [1:0] SEL_MEM  = 2'd0;
    localparam logic [1:0] SEL_IO   = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int unsigned MAR_W = 24,
    parameter int unsigned IO_W  = 16,
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [MAR_W-1:0]  wr_data,
    input  logic              step,
    output logic [MAR_W-1:0]  mar,
    output logic [IO_W-1:0]   ioar,
    output logic [CNT_W-1:0]  cnt,
    output dmach_ctrl_t       ctrl,
    output logic              done,
    output logic              last
);

    logic [MAR_W-1:0] stride;
    logic [MAR_W-1:0] mar_next;

    assign last     = (cnt == CNT_W'(1));
    assign stride   = ctrl.word ? MAR_W'(2) : MAR_W'(1);
    assign mar_next = ctrl.step_down ? (mar - stride) : (mar + stride);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mar  <= '0;
            ioar <= '0;
            cnt  <= '0;
            ctrl <= '0;
            done <= 1'b0;
        end else if (step) begin
            mar <= mar_next;
            cnt <= cnt - CNT_W'(1);
            if (last) begin
                ctrl.en <= 1'b0;
                done    <= 1'b1;
            end
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_MEM:  mar  <= wr_data;
                SEL_IO:   ioar <= wr_data[IO_W-1:0];
                SEL_CNT:  cnt  <= wr_data[CNT_W-1:0];
                SEL_CTRL: begin
                    ctrl <= dmach_ctrl_t'(wr_data[CTRL_W-1:0]);
                    done <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
    import dmach_pkg::*;
#(
    parameter int unsigned MAR_W  = 24,
    parameter int unsigned IO_W   = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              en,
    input  logic              last,
    input  logic              word,
    input  logic              dir_in,
    input  logic [MAR_W-1:0]  mar,
    input  logic [IO_W-1:0]   ioar,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [MAR_W-1:0]  bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              step
);

    localparam int unsigned PAGE_W = MAR_W - IO_W;
    localparam int unsigned BYTE_W = 8;

    dmach_state_e     state_q, state_d;
    logic             pend_q;
    logic [DATA_W-1:0] latch_q;
    logic [MAR_W-1:0] io_addr;
    logic [MAR_W-1:0] src_addr;
    logic [MAR_W-1:0] dst_addr;
    logic             start;

    assign io_addr  = {{PAGE_W{1'b1}}, ioar};
    assign src_addr = dir_in ? io_addr : mar;
    assign dst_addr = dir_in ? mar : io_addr;
    assign start    = en && (req || pend_q);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register, pending request and data latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            latch_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                if (start) pend_q <= 1'b0;
            end else if (state_q == ST_WRITE && last) begin
                pend_q <= 1'b0;
            end else if (req) begin
                pend_q <= 1'b1;
            end
            if (state_q == ST_READ) begin
                latch_q <= word ? bus_rdata
                                : {{(DATA_W-BYTE_W){1'b0}}, bus_rdata[BYTE_W-1:0]};
            end
        end
    end

    // outputs
    always_comb begin
        bus_addr  = '0;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        busy      = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                bus_addr = src_addr;
                bus_rd   = 1'b1;
                busy     = 1'b1;
            end
            ST_WRITE: begin
                bus_addr  = dst_addr;
                bus_wr    = 1'b1;
                bus_wdata = latch_q;
                busy      = 1'b1;
                step      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
    import dmach_pkg::*;
#(
    parameter int unsigned MAR_W  = 24,
    parameter int unsigned IO_W   = 16,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [MAR_W-1:0]  cfg_wdata,
    output logic [MAR_W-1:0]  cfg_rdata,
    input  logic              req,
    output logic [MAR_W-1:0]  bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              irq
);

    localparam int unsigned DONE_BIT = 7;

    logic [MAR_W-1:0] mar_q;
    logic [IO_W-1:0]  ioar_q;
    logic [CNT_W-1:0] cnt_q;
    dmach_ctrl_t      ctrl_q;
    logic             last_x;
    logic             step_x;
    logic             done_q;

    dmach_regs #(.MAR_W(MAR_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && !busy),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .step    (step_x),
        .mar     (mar_q),
        .ioar    (ioar_q),
        .cnt     (cnt_q),
        .ctrl    (ctrl_q),
        .done    (done_q),
        .last    (last_x)
    );

    dmach_fsm #(.MAR_W(MAR_W), .IO_W(IO_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .en        (ctrl_q.en),
        .last      (last_x),
        .word      (ctrl_q.word),
        .dir_in    (ctrl_q.dir_in),
        .mar       (mar_q),
        .ioar      (ioar_q),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .step      (step_x)
    );

    assign done = done_q;
    assign irq  = done_q && ctrl_q.irq_en;

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_sel)
            SEL_MEM:  cfg_rdata = mar_q;
            SEL_IO:   cfg_rdata[IO_W-1:0] = ioar_q;
            SEL_CNT:  cfg_rdata[CNT_W-1:0] = cnt_q;
            SEL_CTRL: begin
                cfg_rdata[CTRL_W-1:0] = ctrl_q;
                cfg_rdata[DONE_BIT]   = done_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dmach_checker.sv
module dmach_checker #(
    parameter int unsigned MAR_W = 24,
    parameter int unsigned IO_W  = 16,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [MAR_W-1:0] bus_addr,
    input logic             done,
    input logic             irq,
    input logic             dir_in,
    input logic [CNT_W-1:0] cnt,
    input logic [IO_W-1:0]  ioar
);

    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);

    a_r4_io_page_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !dir_in) |-> (bus_addr[MAR_W-1:IO_W] == '1));

    a_r4_io_page_src: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dir_in) |-> (bus_addr[MAR_W-1:IO_W] == '1));

    a_r7_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

    a_r7_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_we) |=> done);

    a_r9_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> ($stable(cnt) && $stable(ioar)));

endmodule

bind dma_seq_chan dmach_checker #(.MAR_W(MAR_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .done     (done),
    .irq      (irq),
    .dir_in   (ctrl_q.dir_in),
    .cnt      (cnt_q),
    .ioar     (ioar_q)
);

// File: tb/test_dma_seq_chan.sv
module test_dma_seq_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        req = 1'b0;
    logic [23:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        busy;
    logic        done;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // memory model: data is a function of the address
    assign bus_rdata = bus_addr[15:0] ^ 16'hA5C3;

    dma_seq_chan i_dma_seq_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .done(done), .irq(irq)
    );

    function automatic logic [15:0] mem_data(input logic [23:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [23:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [23:0] val);
        cfg_sel = sel;
        #1 val = cfg_rdata;
    endtask

    // one request; checks the read cycle and the write cycle
    task automatic one_xfer(input string tag, input logic [23:0] src,
                            input logic [23:0] dst, input logic word);
        logic [15:0] d;
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        chk({tag, " R3 rd"}, bus_rd, 1'b1);
        chk({tag, " R4 src"}, bus_addr, src);
        d = mem_data(src);
        if (!word) d = {8'h00, d[7:0]};
        @(negedge clk);
        chk({tag, " R3 wr"}, bus_wr, 1'b1);
        chk({tag, " R4 dst"}, bus_addr, dst);
        chk({tag, " R6 data"}, bus_wdata, d);
        @(negedge clk);
        chk({tag, " R3 idle"}, {bus_rd, bus_wr, busy}, 3'b000);
    endtask

    task automatic t_reset;
        logic [23:0] v;
        @(negedge clk);
        chk("R1 strobes", {bus_rd, bus_wr, busy, done, irq}, 5'b0);
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            chk("R1 reg zero", v, 24'h0);
        end
    endtask

    task automatic t_regs;
        logic [23:0] v;
        wr_reg(2'd0, 24'hC0FFEE);
        wr_reg(2'd1, 24'h55AA77);
        wr_reg(2'd2, 24'h129876);
        rd_reg(2'd0, v); chk("R2 mem", v, 24'hC0FFEE);
        rd_reg(2'd1, v); chk("R2 io", v, 24'h00AA77);
        rd_reg(2'd2, v); chk("R2 cnt", v, 24'h009876);
    endtask

    task automatic t_word_out;
        logic [23:0] v;
        wr_reg(2'd0, 24'h012340);
        wr_reg(2'd1, 24'h000200);
        wr_reg(2'd2, 24'h000003);
        wr_reg(2'd3, 24'h000013);
        one_xfer("w1", 24'h012340, 24'hFF0200, 1'b1);
        rd_reg(2'd2, v); chk("R7 cnt after 1", v, 24'd2);
        chk("R7 not done", done, 1'b0);
        one_xfer("w2", 24'h012342, 24'hFF0200, 1'b1);
        one_xfer("w3", 24'h012344, 24'hFF0200, 1'b1);
        rd_reg(2'd0, v); chk("R5 word inc", v, 24'h012346);
        rd_reg(2'd2, v); chk("R7 cnt zero", v, 24'd0);
        rd_reg(2'd3, v); chk("R7 ctrl en cleared", v, 24'h000092);
        chk("R7 irq", irq, 1'b1);
    endtask

    task automatic t_ignored_after_done;
        logic [23:0] v;
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R8 no bus when disabled", {bus_rd, bus_wr}, 2'b00);
            @(negedge clk);
        end
        chk("R8 done sticky", done, 1'b1);
        wr_reg(2'd3, 24'h000000);
        rd_reg(2'd3, v); chk("R8 done cleared", v, 24'h0);
        chk("R8 irq low", irq, 1'b0);
    endtask

    task automatic t_byte_in_wrap;
        logic [23:0] v;
        wr_reg(2'd0, 24'h000000);
        wr_reg(2'd1, 24'h001234);
        wr_reg(2'd2, 24'h000002);
        wr_reg(2'd3, 24'h00000D);
        one_xfer("b1", 24'hFF1234, 24'h000000, 1'b0);
        rd_reg(2'd0, v); chk("R5 down wrap", v, 24'hFFFFFF);
        one_xfer("b2", 24'hFF1234, 24'hFFFFFF, 1'b0);
        rd_reg(2'd0, v); chk("R5 byte dec", v, 24'hFFFFFE);
        rd_reg(2'd3, v); chk("R7 ctrl byte run", v, 24'h00008C);
        chk("R7 irq masked", {done, irq}, 2'b10);
    endtask

    task automatic t_busy_collisions;
        logic [23:0] v;
        wr_reg(2'd0, 24'h000100);
        wr_reg(2'd1, 24'h000010);
        wr_reg(2'd2, 24'h000002);
        wr_reg(2'd3, 24'h000003);
        @(negedge clk); req = 1'b1;
        @(negedge clk);
        chk("R3 rd c1", bus_rd, 1'b1);
        // request and register write during the read cycle
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 24'hABCDEF;
        @(negedge clk); req = 1'b0; cfg_we = 1'b0;
        chk("R3 wr c1", bus_wr, 1'b1);
        @(negedge clk);
        chk("R10 idle gap", bus_rd, 1'b0);
        rd_reg(2'd0, v); chk("R9 write blocked", v, 24'h000102);
        @(negedge clk);
        chk("R10 pending served", bus_rd, 1'b1);
        chk("R10 pending src", bus_addr, 24'h000102);
        @(negedge clk);
        chk("R10 final wr", bus_wr, 1'b1);
        req = 1'b1;
        @(negedge clk); req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R10 req at end dropped", bus_rd, 1'b0);
            @(negedge clk);
        end
        rd_reg(2'd2, v); chk("R7 cnt zero c", v, 24'd0);
        chk("R8 done c", done, 1'b1);
        rd_reg(2'd0, v); chk("R5 final mem", v, 24'h000104);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_word_out();
        t_ignored_after_done();
        t_byte_in_wrap();
        wr_reg(2'd3, 24'h0);
        t_busy_collisions();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule